// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired sequencer for a small multicycle load/store processor. It holds a 4-bit state register and, in each state, drives the full set of datapath control lines: program-counter write (unconditional and zero-qualified), instruction-register write, memory write, register-file write, destination select, write-back source, memory address source, both ALU operand selects, ALU operation, immediate extension mode and program-counter source. The outputs depend only on the current state (Moore style).

The next state is a direct logic function of the current state and the 6-bit opcode. Every instruction starts with a fetch state and a decode state. The decode state then dispatches to a separate path for each instruction class: load, store, register-register, OR-immediate, branch-if-equal and jump. Each path returns to fetch when it completes. The datapath, memories and ALU sit outside this block. They consume the control lines, and they supply the opcode from the instruction register.

Top module: `mc_ctrl_top`

## Requirements
- R1: While `rst_n` is low, `state` is 0 and the outputs show the fetch pattern. This happens at once, without waiting for a clock edge.
- R2: State 0 (fetch) asserts `pc_wr` and `ir_wr`. It sets `alu_op`=00 (add), `alu_sel_a`=0 (PC), `alu_sel_b`=001 (constant 4) and `pc_src`=00 (ALU result). All other outputs are 0. The next state is always 1.
- R3: State 1 (decode) sets `alu_op`=00, `alu_sel_b`=011 (sign-extended immediate shifted left by 2) and `ext_sel`=1, with all other outputs 0. It dispatches on the opcode. Opcodes 100011 (load) and 101011 (store) go to 2. Opcode 000000 (register-register) goes to 6. Opcode 000100 (branch-equal) goes to 8. Opcode 000010 (jump) goes to 9. Opcode 001011 (OR-immediate) goes to 10. Any other opcode goes to 0.
- R4: State 2 (address calculation) sets `alu_sel_a`=1, `alu_sel_b`=010 (sign-extended immediate), `ext_sel`=1 and `alu_op`=00. It goes to 3 if the opcode is load, to 5 if the opcode is store, and to 0 for any other opcode.
- R5: The load path runs 3 then 4 then 0. In state 3, `addr_sel`=1 (ALU result as memory address) and the operands are the same as in state 2. State 4 adds `reg_wr`=1 and `mem_to_reg`=1, with `reg_dst`=0.
- R6: State 5 (store) asserts `mem_wr` and `addr_sel`, uses the operands of state 2, and goes to 0.
- R7: The register-register path runs 6 then 7 then 0. Both states set `alu_sel_a`=1, `alu_sel_b`=000 (register) and `alu_op`=10 (function field). State 7 also asserts `reg_wr` and `reg_dst`=1.
- R8: State 8 (branch) asserts `pc_wr_cond` and sets `alu_op`=01 (subtract), `alu_sel_a`=1, `alu_sel_b`=000 and `pc_src`=01 (branch target). It goes to 0.
- R9: State 9 (jump) asserts `pc_wr` with `pc_src`=10 (jump address), with all other outputs 0. It goes to 0.
- R10: The OR-immediate path runs 10 then 11 then 0. Both states set `alu_op`=11 (OR), `alu_sel_a`=1, `alu_sel_b`=100 (zero-extended immediate) and `ext_sel`=0. State 11 also asserts `reg_wr` with `reg_dst`=0.
- R11: `state` never exceeds 11. `pc_wr` and `pc_wr_cond` are never high together, and neither are `mem_wr` and `reg_wr`. If the register ever holds an undefined code, all outputs are 0 and the next state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field from the instruction register |
| state | output | 4 | Current state number, plain binary |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by ALU zero |
| ir_wr | output | 1 | Instruction register write |
| mem_wr | output | 1 | Memory write |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Destination select: 1 = rd field, 0 = rt field |
| mem_to_reg | output | 1 | Write-back source: 1 = memory, 0 = ALU |
| addr_sel | output | 1 | Memory address: 1 = ALU result, 0 = PC |
| alu_sel_a | output | 1 | First ALU operand: 1 = register, 0 = PC |
| alu_sel_b | output | 3 | Second ALU operand select |
| alu_op | output | 2 | ALU operation |
| ext_sel | output | 1 | Immediate extension: 1 = sign, 0 = zero |
| pc_src | output | 2 | PC source select |

## Verification
The properties assume that `opcode` carries a defined 6-bit value at every rising edge and does not change across that edge. They also assume that `rst_n` is the only route back to fetch outside the normal sequence. The bench changes the opcode and reset only on falling edges. It mixes all six legal opcodes with arbitrary 6-bit codes, so that the fall-back to fetch is exercised both in decode and in address calculation. It also applies one reset in the middle of the run to exercise the asynchronous clear.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  localparam int OPC_W  = 6;
  localparam int ST_W   = 4;
  localparam int SELB_W = 3;
  localparam int AOP_W  = 2;
  localparam int PCS_W  = 2;
  localparam int N_ST   = 12;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_RREG  = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_ORIM  = 6'b001011;
  localparam logic [OPC_W-1:0] OPC_BREQ  = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'd0,  S_DECODE = 4'd1,  S_ADDR   = 4'd2,  S_LDMEM  = 4'd3,
    S_LDWB   = 4'd4,  S_STMEM  = 4'd5,  S_RRX    = 4'd6,  S_RRWB   = 4'd7,
    S_BRANCH = 4'd8,  S_JUMP   = 4'd9,  S_ORX    = 4'd10, S_ORWB   = 4'd11
  } state_t;

  typedef enum logic [2:0] {
    CL_NONE, CL_LOAD, CL_STORE, CL_RREG, CL_ORIM, CL_BREQ, CL_JUMP
  } iclass_t;

  localparam logic [AOP_W-1:0] AOP_ADD = 2'b00;
  localparam logic [AOP_W-1:0] AOP_SUB = 2'b01;
  localparam logic [AOP_W-1:0] AOP_FN  = 2'b10;
  localparam logic [AOP_W-1:0] AOP_OR  = 2'b11;

  localparam logic [SELB_W-1:0] SB_REG   = 3'b000;
  localparam logic [SELB_W-1:0] SB_FOUR  = 3'b001;
  localparam logic [SELB_W-1:0] SB_SEXT  = 3'b010;
  localparam logic [SELB_W-1:0] SB_SEXT2 = 3'b011;
  localparam logic [SELB_W-1:0] SB_ZEXT  = 3'b100;

  localparam logic [PCS_W-1:0] PCS_ALU = 2'b00;
  localparam logic [PCS_W-1:0] PCS_TGT = 2'b01;
  localparam logic [PCS_W-1:0] PCS_JMP = 2'b10;

  typedef struct packed {
    logic              pc_wr;
    logic              pc_wr_cond;
    logic              ir_wr;
    logic              mem_wr;
    logic              reg_wr;
    logic              reg_dst;
    logic              mem_to_reg;
    logic              addr_sel;
    logic              alu_sel_a;
    logic [SELB_W-1:0] alu_sel_b;
    logic [AOP_W-1:0]  alu_op;
    logic              ext_sel;
    logic [PCS_W-1:0]  pc_src;
  } ctrl_t;
endpackage

// File: rtl/mc_opc_decode.sv
module mc_opc_decode
  import mc_ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output iclass_t          iclass
);
  always_comb begin
    case (opcode)
      OPC_LOAD:  iclass = CL_LOAD;
      OPC_STORE: iclass = CL_STORE;
      OPC_RREG:  iclass = CL_RREG;
      OPC_ORIM:  iclass = CL_ORIM;
      OPC_BREQ:  iclass = CL_BREQ;
      OPC_JUMP:  iclass = CL_JUMP;
      default:   iclass = CL_NONE;
    endcase
  end
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  state_t  cur,
  input  iclass_t iclass,
  output state_t  nxt
);
  always_comb begin
    nxt = S_FETCH;
    case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        case (iclass)
          CL_LOAD, CL_STORE: nxt = S_ADDR;
          CL_RREG:           nxt = S_RRX;
          CL_BREQ:           nxt = S_BRANCH;
          CL_JUMP:           nxt = S_JUMP;
          CL_ORIM:           nxt = S_ORX;
          default:           nxt = S_FETCH;
        endcase
      end
      S_ADDR: begin
        if (iclass == CL_LOAD)       nxt = S_LDMEM;
        else if (iclass == CL_STORE) nxt = S_STMEM;
        else                         nxt = S_FETCH;
      end
      S_LDMEM: nxt = S_LDWB;
      S_RRX:   nxt = S_RRWB;
      S_ORX:   nxt = S_ORWB;
      default: nxt = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_rom.sv
module mc_ctrl_rom
  import mc_ctrl_pkg::*;
(
  input  state_t cur,
  output ctrl_t  ctrl
);
  always_comb begin
    ctrl = '0;
    case (cur)
      S_FETCH: begin
        ctrl.pc_wr     = 1'b1;
        ctrl.ir_wr     = 1'b1;
        ctrl.alu_sel_b = SB_FOUR;
        ctrl.alu_op    = AOP_ADD;
        ctrl.pc_src    = PCS_ALU;
      end
      S_DECODE: begin
        ctrl.alu_sel_b = SB_SEXT2;
        ctrl.alu_op    = AOP_ADD;
        ctrl.ext_sel   = 1'b1;
      end
      S_ADDR, S_LDMEM, S_LDWB, S_STMEM: begin
        ctrl.alu_sel_a = 1'b1;
        ctrl.alu_sel_b = SB_SEXT;
        ctrl.alu_op    = AOP_ADD;
        ctrl.ext_sel   = 1'b1;
        ctrl.addr_sel  = (cur != S_ADDR);
        ctrl.reg_wr    = (cur == S_LDWB);
        ctrl.mem_to_reg = (cur == S_LDWB);
        ctrl.mem_wr    = (cur == S_STMEM);
      end
      S_RRX, S_RRWB: begin
        ctrl.alu_sel_a = 1'b1;
        ctrl.alu_sel_b = SB_REG;
        ctrl.alu_op    = AOP_FN;
        ctrl.reg_wr    = (cur == S_RRWB);
        ctrl.reg_dst   = (cur == S_RRWB);
      end
      S_BRANCH: begin
        ctrl.pc_wr_cond = 1'b1;
        ctrl.alu_sel_a  = 1'b1;
        ctrl.alu_sel_b  = SB_REG;
        ctrl.alu_op     = AOP_SUB;
        ctrl.pc_src     = PCS_TGT;
      end
      S_JUMP: begin
        ctrl.pc_wr  = 1'b1;
        ctrl.pc_src = PCS_JMP;
      end
      S_ORX, S_ORWB: begin
        ctrl.alu_sel_a = 1'b1;
        ctrl.alu_sel_b = SB_ZEXT;
        ctrl.alu_op    = AOP_OR;
        ctrl.reg_wr    = (cur == S_ORWB);
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_top.sv
module mc_ctrl_top
  import mc_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ST_W-1:0]   state,
  output logic              pc_wr,
  output logic              pc_wr_cond,
  output logic              ir_wr,
  output logic              mem_wr,
  output logic              reg_wr,
  output logic              reg_dst,
  output logic              mem_to_reg,
  output logic              addr_sel,
  output logic              alu_sel_a,
  output logic [SELB_W-1:0] alu_sel_b,
  output logic [AOP_W-1:0]  alu_op,
  output logic              ext_sel,
  output logic [PCS_W-1:0]  pc_src
);
  state_t  state_q;
  state_t  state_d;
  iclass_t iclass;
  ctrl_t   ctrl;

  mc_opc_decode u_dec (.opcode(opcode), .iclass(iclass));
  mc_next_state u_ns  (.cur(state_q), .iclass(iclass), .nxt(state_d));
  mc_ctrl_rom   u_rom (.cur(state_q), .ctrl(ctrl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_FETCH;
    else        state_q <= state_d;
  end

  assign state      = state_q;
  assign pc_wr      = ctrl.pc_wr;
  assign pc_wr_cond = ctrl.pc_wr_cond;
  assign ir_wr      = ctrl.ir_wr;
  assign mem_wr     = ctrl.mem_wr;
  assign reg_wr     = ctrl.reg_wr;
  assign reg_dst    = ctrl.reg_dst;
  assign mem_to_reg = ctrl.mem_to_reg;
  assign addr_sel   = ctrl.addr_sel;
  assign alu_sel_a  = ctrl.alu_sel_a;
  assign alu_sel_b  = ctrl.alu_sel_b;
  assign alu_op     = ctrl.alu_op;
  assign ext_sel    = ctrl.ext_sel;
  assign pc_src     = ctrl.pc_src;
endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk
  import mc_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [OPC_W-1:0]  opcode,
  input logic [ST_W-1:0]   state,
  input logic              pc_wr,
  input logic              pc_wr_cond,
  input logic              mem_wr,
  input logic              reg_wr,
  input logic              addr_sel
);
  logic opc_known;
  assign opc_known = (opcode == OPC_LOAD) || (opcode == OPC_STORE) ||
                     (opcode == OPC_RREG) || (opcode == OPC_ORIM)  ||
                     (opcode == OPC_BREQ) || (opcode == OPC_JUMP);

  AST_RESET_HOLDS_FETCH: assert property (@(posedge clk) !rst_n |-> state == 4'd0); // R1
  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd0 |=> state == 4'd1); // R2
  AST_DECODE_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd1 && !opc_known) |=> state == 4'd0); // R3
  AST_ADDR_TO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd2 && opcode == OPC_LOAD) |=> state == 4'd3); // R4
  AST_LOAD_READ_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd3 |=> state == 4'd4); // R5
  AST_STORE_ADDR_ALU: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> addr_sel); // R6
  AST_FINAL_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd7 || state == 4'd8 || state == 4'd9 || state == 4'd11) |=> state == 4'd0); // R7
  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    state <= 4'd11); // R11
  AST_PC_WRITE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_wr && pc_wr_cond)); // R11
  AST_WRITE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && reg_wr)); // R11
endmodule

bind mc_ctrl_top mc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .opcode(opcode), .state(state),
  .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .mem_wr(mem_wr),
  .reg_wr(reg_wr), .addr_sel(addr_sel)
);

// File: tb/tb_mc_ctrl_top.sv
module tb_mc_ctrl_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic [3:0] state;
  logic pc_wr, pc_wr_cond, ir_wr, mem_wr, reg_wr, reg_dst, mem_to_reg, addr_sel, alu_sel_a, ext_sel;
  logic [2:0] alu_sel_b;
  logic [1:0] alu_op, pc_src;

  int n_vec = 0;
  int n_bad = 0;
  int exp_state;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mc_ctrl_top dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .state(state),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .ir_wr(ir_wr), .mem_wr(mem_wr),
    .reg_wr(reg_wr), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .addr_sel(addr_sel),
    .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b), .alu_op(alu_op),
    .ext_sel(ext_sel), .pc_src(pc_src)
  );

  // packing: pc_wr,pc_wr_cond,ir_wr,mem_wr,reg_wr,reg_dst,mem_to_reg,addr_sel,alu_sel_a,sel_b[3],op[2],ext,pc_src[2]
  function automatic logic [16:0] pack(logic pw, pwc, irw, mw, rw, rd, m2r, asel, sa,
                                       logic [2:0] sb, logic [1:0] op, logic ex, logic [1:0] ps);
    return {pw, pwc, irw, mw, rw, rd, m2r, asel, sa, sb, op, ex, ps};
  endfunction

  function automatic logic [16:0] exp_ctrl(int s);
    case (s)
      0:  return pack(1,0,1,0,0,0,0,0,0, 3'b001, 2'b00, 0, 2'b00);
      1:  return pack(0,0,0,0,0,0,0,0,0, 3'b011, 2'b00, 1, 2'b00);
      2:  return pack(0,0,0,0,0,0,0,0,1, 3'b010, 2'b00, 1, 2'b00);
      3:  return pack(0,0,0,0,0,0,0,1,1, 3'b010, 2'b00, 1, 2'b00);
      4:  return pack(0,0,0,0,1,0,1,1,1, 3'b010, 2'b00, 1, 2'b00);
      5:  return pack(0,0,0,1,0,0,0,1,1, 3'b010, 2'b00, 1, 2'b00);
      6:  return pack(0,0,0,0,0,0,0,0,1, 3'b000, 2'b10, 0, 2'b00);
      7:  return pack(0,0,0,0,1,1,0,0,1, 3'b000, 2'b10, 0, 2'b00);
      8:  return pack(0,1,0,0,0,0,0,0,1, 3'b000, 2'b01, 0, 2'b01);
      9:  return pack(1,0,0,0,0,0,0,0,0, 3'b000, 2'b00, 0, 2'b10);
      10: return pack(0,0,0,0,0,0,0,0,1, 3'b100, 2'b11, 0, 2'b00);
      11: return pack(0,0,0,0,1,0,0,0,1, 3'b100, 2'b11, 0, 2'b00);
      default: return '0;
    endcase
  endfunction

  function automatic int exp_next(int s, logic [5:0] op);
    case (s)
      0: return 1;
      1: case (op)
           6'b100011, 6'b101011: return 2;
           6'b000000: return 6;
           6'b000100: return 8;
           6'b000010: return 9;
           6'b001011: return 10;
           default:   return 0;
         endcase
      2: return (op == 6'b100011) ? 3 : (op == 6'b101011) ? 5 : 0;
      3: return 4;
      6: return 7;
      10: return 11;
      default: return 0;
    endcase
  endfunction

  function automatic string req_tag(int s);
    case (s)
      0: return "R2";   1: return "R3";   2: return "R4";
      3, 4: return "R5"; 5: return "R6"; 6, 7: return "R7";
      8: return "R8";   9: return "R9";   default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [16:0] act, logic [16:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag, int s);
    logic [16:0] act;
    act = pack(pc_wr, pc_wr_cond, ir_wr, mem_wr, reg_wr, reg_dst, mem_to_reg, addr_sel,
               alu_sel_a, alu_sel_b, alu_op, ext_sel, pc_src);
    chk(tag, "state", {13'd0, state}, 17'(s));
    chk(tag, "controls", act, exp_ctrl(s));
    // R11 exclusivity, observed at the ports
    chk("R11", "write exclusivity",
        {15'd0, pc_wr & pc_wr_cond, mem_wr & reg_wr}, 17'd0);
  endtask

  function automatic logic [5:0] pick_opc(int i);
    logic [5:0] tbl [7];
    tbl = '{6'b100011, 6'b101011, 6'b000000, 6'b001011, 6'b000100, 6'b000010, 6'b111111};
    if (i < 140) return tbl[(i / 2) % 7];
    case ($urandom_range(0, 9))
      0, 1: return tbl[0];
      2:    return tbl[1];
      3:    return tbl[2];
      4:    return tbl[3];
      5:    return tbl[4];
      6:    return tbl[5];
      default: return 6'($urandom());
    endcase
  endfunction

  initial begin
    #100000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    rst_n  = 1'b1;
    opcode = 6'b000000;
    #1 rst_n = 1'b0;
    #0.5;
    check_all("R1", 0);            // R1 asynchronous clear before any edge
    repeat (2) @(negedge clk);
    check_all("R1", 0);            // R1 held across edges
    rst_n = 1'b1;
    exp_state = 0;
    for (int i = 0; i < 4000; i++) begin
      check_all(req_tag(exp_state), exp_state);
      if (i == 2001) begin
        rst_n = 1'b0;              // R1 mid-run reset
        #1;
        check_all("R1", 0);
        @(negedge clk);
        check_all("R1", 0);
        rst_n = 1'b1;
        exp_state = 0;
        continue;
      end
      opcode = pick_opc(i);
      exp_state = exp_next(exp_state, opcode);
      @(negedge clk);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule